// File: doc/BRIEF.md
# Streaming Prefix Hasher with Shift-Add-XOR Chain

This unit hashes a stream of 8-bit characters so that a bank of per-length dictionaries can be probed on every cycle. For each accepted character it produces one hash for every key length from 1 up to `LEN`. The key of length k is made of the k most recent characters, read from the newest one backwards. All hashes come from one chain of shift-add-xor steps. Stage k takes the stage k-1 value and folds in exactly one more character, so no stage rehashes the whole key.

The starting value of the chain (the seed) selects which member of the hash family is in use. The seed is the state of an internal maximal-length LFSR. When the surrounding table logic asks for a rehash, it pulses a reseed request during a cycle with no character. The LFSR then steps once, which gives a new hash function, and the count of characters seen starts again from zero.

Each output is registered. All lengths appear together in the cycle after their character was presented. Every length has its own valid flag, which tells whether enough characters have arrived to fill a key of that length.

Top module: `sax_prefix_hasher`

## Requirements
- R1: One chain step maps a 16-bit value h and a character c to h XOR ((h << 5) + (h >> 2) + c). The shifts are logical, the sum is taken modulo 2^16, and c is zero-extended.
- R2: The length-k hash starts the chain from the current seed and applies k steps. Step 1 uses the newest character and step j uses the j-th most recent accepted character. The output is the low 9 bits of the result.
- R3: A character presented with charValid high in one cycle produces its hashes and flags in the next cycle, all lengths in that same cycle.
- R4: After each accepted character, the flag of length k (hashValid bit k-1) is 1 for one cycle exactly when at least k characters have been accepted since reset or the last reseed. The flags are 0 in any cycle that follows a cycle without a character.
- R5: The hash outputs keep their values through cycles in which no character is accepted.
- R6: Reset clears all flags and hash outputs to 0, clears the character count, and sets the seed and LFSR state to 0xACE1.
- R7: A reseedReq pulse in a cycle with charValid low steps the LFSR once and clears the character count. The LFSR is Galois, right-shifting, and XORs in the mask 0xB400 when the bit shifted out is 1. The new state becomes the seed. The LFSR state is never zero.
- R8: A reseedReq in a cycle with charValid high is ignored. The seed and the count are unchanged, and the character is hashed normally.
- R9: The length-k hash sits on hashOut bits [9k-1 : 9(k-1)].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| charValid | input | 1 | charIn carries a character this cycle |
| charIn | input | 8 | Incoming character |
| reseedReq | input | 1 | Request for a new seed; honoured only when charValid is low |
| hashOut | output | 144 | Sixteen 9-bit hashes, length 1 in the lowest slice |
| hashValid | output | 16 | Per-length valid flags, bit k-1 for length k |

## Verification
The assertions assume that charValid and reseedReq are known and 0 or 1 on every clock edge after reset. They also treat a reseed that arrives together with a character as a non-event, so they expect the seed to move only on idle reseed cycles. The bench drives every input on the falling edge, never leaves an input undriven, and applies reseed both on its own and together with a character, which exercises both branches of that rule. Character values include zero, 0xFF and mixed bytes, so the carries of the modular sum are exercised across the whole chain.

// File: rtl/sax_pkg.sv
package sax_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic accept;   // a character is taken this cycle
    logic reseed;   // an idle-cycle reseed is taken this cycle
  } ctrlStrobe_t;
endpackage

// File: rtl/sax_lfsr.sv
module sax_lfsr #(
  parameter int             WIDTH     = 16,
  parameter logic [WIDTH-1:0] TAPS    = 16'hB400,
  parameter logic [WIDTH-1:0] INIT    = 16'hACE1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             step,
  output logic [WIDTH-1:0] state
);
  logic [WIDTH-1:0] nextState;

  always_comb begin
    nextState = {1'b0, state[WIDTH-1:1]};
    if (state[0]) nextState = nextState ^ TAPS;
  end

  always_ff @(posedge clk) begin
    if (!rstN)     state <= INIT;
    else if (step) state <= nextState;
  end

  // R7: a maximal-length register never falls into the all-zero lock state
  assert_lfsr_nonzero_R7: assert property (@(posedge clk) disable iff (!rstN)
    state != '0);
endmodule

// File: rtl/sax_ctrl.sv
module sax_ctrl
  import sax_pkg::*;
#(
  parameter int LEN = 16,
  parameter int HW  = 16,
  parameter logic [HW-1:0] SEED_INIT = 16'hACE1,
  parameter logic [HW-1:0] LFSR_TAPS = 16'hB400
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          charValid,
  input  logic          reseedReq,
  output ctrlStrobe_t   strobe,
  output logic [LEN-1:0] validMask,
  output logic [HW-1:0] seed
);
  localparam int CW = $clog2(LEN + 1);

  logic [CW-1:0] fillCnt;

  assign strobe.accept = charValid;
  assign strobe.reseed = reseedReq && !charValid;

  sax_lfsr #(.WIDTH(HW), .TAPS(LFSR_TAPS), .INIT(SEED_INIT)) u_lfsr (
    .clk   (clk),
    .rstN  (rstN),
    .step  (strobe.reseed),
    .state (seed)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fillCnt <= '0;
    end else if (strobe.reseed) begin
      fillCnt <= '0;
    end else if (strobe.accept && fillCnt != CW'(LEN)) begin
      fillCnt <= fillCnt + 1'b1;
    end
  end

  // Length k+1 is complete once k earlier characters plus the current one exist
  for (genvar k = 0; k < LEN; k++) begin : g_mask
    assign validMask[k] = (fillCnt >= CW'(k));
  end

  // R4: the count saturates at the longest key length
  assert_count_bound_R4: assert property (@(posedge clk) disable iff (!rstN)
    fillCnt <= CW'(LEN));

  // R7: an idle reseed always moves to a different seed
  assert_reseed_moves_R7: assert property (@(posedge clk) disable iff (!rstN)
    (reseedReq && !charValid) |=> seed != $past(seed));

  // R8: a reseed request during a character is ignored
  assert_busy_reseed_ignored_R8: assert property (@(posedge clk) disable iff (!rstN)
    (reseedReq && charValid) |=> $stable(seed));

  // R7: the seed moves only on a reseed request
  assert_seed_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    !reseedReq |=> $stable(seed));
endmodule

// File: rtl/sax_datapath.sv
module sax_datapath
  import sax_pkg::*;
#(
  parameter int LEN  = 16,
  parameter int HW   = 16,
  parameter int OUTW = 9,
  parameter int SHL  = 5,
  parameter int SHR  = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctrlStrobe_t         strobe,
  input  logic [LEN-1:0]      validMask,
  input  logic [HW-1:0]       seed,
  input  logic [7:0]          charIn,
  output logic [LEN*OUTW-1:0] hashOut,
  output logic [LEN-1:0]      hashValid
);
  localparam int HIST = LEN - 1;

  logic [7:0]          histChar [HIST];
  logic [HW-1:0]       chainH   [LEN+1];
  logic [LEN*OUTW-1:0] nextHash;

  // History of earlier characters, histChar[0] is the one before charIn
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int j = 0; j < HIST; j++) histChar[j] <= '0;
    end else if (strobe.accept) begin
      histChar[0] <= charIn;
      for (int j = 1; j < HIST; j++) histChar[j] <= histChar[j-1];
    end
  end

  assign chainH[0] = seed;

  for (genvar k = 0; k < LEN; k++) begin : g_stage
    logic [7:0]    stageChar;
    logic [HW-1:0] mixTerm;
    if (k == 0) begin : g_first
      assign stageChar = charIn;
    end else begin : g_rest
      assign stageChar = histChar[k-1];
    end
    assign mixTerm     = (chainH[k] << SHL) + (chainH[k] >> SHR)
                       + {{(HW-8){1'b0}}, stageChar};
    assign chainH[k+1] = chainH[k] ^ mixTerm;
    assign nextHash[k*OUTW +: OUTW] = chainH[k+1][OUTW-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hashOut   <= '0;
      hashValid <= '0;
    end else begin
      hashValid <= strobe.accept ? validMask : '0;
      if (strobe.accept) hashOut <= nextHash;
    end
  end

  // R4: valid lengths always form a run starting at length 1
  assert_valid_run_R4: assert property (@(posedge clk) disable iff (!rstN)
    (hashValid & (hashValid + 1'b1)) == '0);

  // R5: hashes hold when no character was taken
  assert_hash_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.accept |=> $stable(hashOut));
endmodule

// File: rtl/sax_prefix_hasher.sv
module sax_prefix_hasher
  import sax_pkg::*;
#(
  parameter int LEN  = 16,
  parameter int HW   = 16,
  parameter int OUTW = 9,
  parameter int SHL  = 5,
  parameter int SHR  = 2,
  parameter logic [HW-1:0] SEED_INIT = 16'hACE1,
  parameter logic [HW-1:0] LFSR_TAPS = 16'hB400
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                charValid,
  input  logic [7:0]          charIn,
  input  logic                reseedReq,
  output logic [LEN*OUTW-1:0] hashOut,
  output logic [LEN-1:0]      hashValid
);
  ctrlStrobe_t    strobe;
  logic [LEN-1:0] validMask;
  logic [HW-1:0]  seed;

  sax_ctrl #(
    .LEN(LEN), .HW(HW), .SEED_INIT(SEED_INIT), .LFSR_TAPS(LFSR_TAPS)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .charValid (charValid),
    .reseedReq (reseedReq),
    .strobe    (strobe),
    .validMask (validMask),
    .seed      (seed)
  );

  sax_datapath #(
    .LEN(LEN), .HW(HW), .OUTW(OUTW), .SHL(SHL), .SHR(SHR)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .validMask (validMask),
    .seed      (seed),
    .charIn    (charIn),
    .hashOut   (hashOut),
    .hashValid (hashValid)
  );

  // R3: every flag is low in the cycle after a cycle without a character
  assert_no_flag_idle_R3: assert property (@(posedge clk) disable iff (!rstN)
    !charValid |=> hashValid == '0);

  // R4: length 1 is flagged after every accepted character
  assert_len1_flag_R4: assert property (@(posedge clk) disable iff (!rstN)
    charValid |=> hashValid[0]);
endmodule

// File: tb/sim_sax_prefix_hasher.sv
module sim_sax_prefix_hasher;
  localparam int CLK_PERIOD = 10;
  localparam int LEN  = 16;
  localparam int OUTW = 9;

  logic                clk = 1'b0;
  logic                rstN;
  logic                charValid;
  logic [7:0]          charIn;
  logic                reseedReq;
  logic [LEN*OUTW-1:0] hashOut;
  logic [LEN-1:0]      hashValid;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // Reference model state
  logic [7:0]  mWin [LEN];
  int          mCnt;
  logic [15:0] mSeed;

  always #(CLK_PERIOD/2) clk = ~clk;

  sax_prefix_hasher u0 (
    .clk(clk), .rstN(rstN), .charValid(charValid), .charIn(charIn),
    .reseedReq(reseedReq), .hashOut(hashOut), .hashValid(hashValid)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] lfsrStep(input logic [15:0] s);
    logic [15:0] n;
    n = {1'b0, s[15:1]};
    if (s[0]) n = n ^ 16'hB400;
    return n;
  endfunction

  // R1 R2: reference hash of length len
  function automatic logic [8:0] expHash(input int len);
    logic [15:0] h;
    logic [15:0] t;
    h = mSeed;
    for (int j = 0; j < len; j++) begin
      t = (h << 5) + (h >> 2) + {8'h00, mWin[j]};
      h = h ^ t;
    end
    return h[8:0];
  endfunction

  task automatic checkAll(input string tag);
    for (int k = 0; k < LEN; k++) begin
      logic expV;
      expV = (mCnt >= k + 1);
      check(hashValid[k] == expV, {tag, " R4 flag"}, 32'(hashValid[k]), 32'(expV));
      if (expV)
        check(hashOut[k*OUTW +: OUTW] == expHash(k + 1), {tag, " R2 R9 hash"},
              32'(hashOut[k*OUTW +: OUTW]), 32'(expHash(k + 1)));
    end
  endtask

  // R3: present a character, sample one edge later
  task automatic pushChar(input logic [7:0] c, input bit withReseed, input string tag);
    charValid = 1'b1;
    charIn    = c;
    reseedReq = withReseed;
    @(negedge clk);
    charValid = 1'b0;
    reseedReq = 1'b0;
    for (int j = LEN - 1; j > 0; j--) mWin[j] = mWin[j-1];
    mWin[0] = c;
    if (mCnt < LEN) mCnt++;
    checkAll(tag);
  endtask

  task automatic testReset;
    rstN = 1'b0; charValid = 1'b0; charIn = '0; reseedReq = 1'b0;
    mCnt = 0; mSeed = 16'hACE1;
    for (int j = 0; j < LEN; j++) mWin[j] = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(hashValid == '0, "R6 flags after reset", 32'(hashValid), 0);
    check(hashOut == '0, "R6 hash after reset", 32'(hashOut[31:0]), 0);
  endtask

  task automatic testFill;
    for (int i = 0; i < 20; i++) pushChar(8'(8'h41 + i * 7), 1'b0, "fill R1 R6");
  endtask

  task automatic testHold;
    logic [LEN*OUTW-1:0] held;
    held = hashOut;
    repeat (3) begin
      @(negedge clk);
      check(hashValid == '0, "R3 R4 idle flags", 32'(hashValid), 0);
      check(hashOut == held, "R5 hold", 32'(hashOut[31:0]), 32'(held[31:0]));
    end
  endtask

  task automatic testReseed;
    reseedReq = 1'b1;
    @(negedge clk);
    reseedReq = 1'b0;
    mSeed = lfsrStep(mSeed);
    mCnt  = 0;
    check(hashValid == '0, "R7 flags after reseed", 32'(hashValid), 0);
    for (int i = 0; i < 18; i++) pushChar(8'(i * 37 + 3), 1'b0, "reseed R7");
  endtask

  task automatic testBusyReseed;
    pushChar(8'h5A, 1'b1, "busy R8");
    check(hashValid[LEN-1] == 1'b1, "R8 count kept", 32'(hashValid[LEN-1]), 1);
    for (int i = 0; i < 4; i++) pushChar(8'(8'hC3 ^ i), 1'b0, "after busy R8");
  endtask

  task automatic testPatterns;
    for (int i = 0; i < 17; i++) pushChar(8'hFF, 1'b0, "ones R1");
    for (int i = 0; i < 17; i++) pushChar(8'h00, 1'b0, "zeros R1");
    for (int r = 0; r < 3; r++) begin
      reseedReq = 1'b1;
      @(negedge clk);
      reseedReq = 1'b0;
      mSeed = lfsrStep(mSeed);
      mCnt  = 0;
      for (int i = 0; i < 5; i++) pushChar(8'(i * 91 + r), 1'b0, "short R4 R7");
    end
  endtask

  initial begin
    testReset();
    testFill();
    testHold();
    testReseed();
    testBusyReseed();
    testHold();
    testPatterns();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule